// File: doc/BRIEF.md
# Prescaled LCD Frame Counter

This block counts LCD frame starts and raises an event every time a programmed number of frames has gone by. It is a down counter that moves only on frame-start strobes. A prescaler can slow it so that it steps once every 1, 2, 4 or 8 frames. When the count passes zero it reloads the top value. The result is a periodic event shared by several consumers: the ready interrupt, blink timing, the animation step, and the data transfer of the frame-counter update mode.

Alongside the one-cycle event, the block keeps a sticky interrupt flag. Each event sets the flag, and software clears it with a clear input. Dropping the enable parks the counter at the top value and empties the prescaler, so the next enable begins a full period.

Top module: `lcd_frame_tally`

## Requirements
- R1: After reset, `frame_event` and `irq_flag` are both 0.
- R2: While `enable` is 0, frame strobes are ignored: `frame_event` stays 0 and no count progress is kept.
- R3: With `pre_sel`=0 and `top_value`=T, the first event follows the (T+1)th frame strobe after enable. Later events follow every T+1 strobes.
- R4: `pre_sel` picks the prescale factor as 0→1, 1→2, 2→4, 3→8. Events then occur every (T+1)·factor frame strobes.
- R5: With `top_value`=0, an event occurs on every prescaled step.
- R6: Clearing `enable` resets both the counter and the prescaler. After at least one disabled cycle, re-enabling restarts a full period.
- R7: `frame_event` is high for exactly the one clock cycle that follows the edge sampling the qualifying strobe.
- R8: `irq_flag` rises together with `frame_event` and stays high until a cycle with `irq_clear`=1 and no event. It is 0 in the cycle after that clear.
- R9: When `irq_clear` and an event coincide, `irq_flag` is set.
- R10: Clock cycles with `frame_tick`=0 do not advance the counter or the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counter run enable |
| top_value | input | CNT_W | Reload value; the period is top_value+1 steps |
| pre_sel | input | 2 | Prescale select: 0→/1, 1→/2, 2→/4, 3→/8 |
| frame_tick | input | 1 | One-cycle frame-start strobe |
| irq_clear | input | 1 | Clears the interrupt flag |
| frame_event | output | 1 | One-cycle event pulse |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest situation to reach from the ports is a clear that lands in the same cycle as an event. That cycle is a single point inside a period of up to several hundred frames. The stimulus reaches it directly by holding `irq_clear` high while the top value is 0 and strobes arrive every cycle. Random traffic also raises the clear often enough that it meets events at arbitrary prescaler phases.

// File: rtl/lcd_frame_tally.sv
module lcd_frame_tally #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] top_value,
  input  logic [1:0]       pre_sel,
  input  logic             frame_tick,
  input  logic             irq_clear,
  output logic             frame_event,
  output logic             irq_flag
);
  localparam int PRE_W = 3;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_last;
  logic             pre_wrap, step, hit;

  assign pre_last = PRE_W'((4'd1 << pre_sel) - 4'd1);
  assign pre_wrap = pre_q >= pre_last;
  assign step     = enable & frame_tick & pre_wrap;
  assign hit      = step & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q       <= '0;
      cnt_q       <= '0;
      frame_event <= 1'b0;
    end else if (!enable) begin
      pre_q       <= '0;
      cnt_q       <= top_value;
      frame_event <= 1'b0;
    end else begin
      if (frame_tick) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (step) cnt_q <= hit ? top_value : cnt_q - 1'b1;
      frame_event <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flag <= 1'b0;
    else        irq_flag <= hit | (irq_flag & ~irq_clear);
  end
endmodule

module lcd_frame_tally_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CNT_W-1:0] top_value,
  input logic             frame_tick,
  input logic             irq_clear,
  input logic             frame_event,
  input logic             irq_flag,
  input logic [CNT_W-1:0] cnt_q
);
  // R2
  event_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_event |-> $past(enable));
  // R10
  event_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_event |-> $past(frame_tick));
  // R8
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_event |-> irq_flag);
  // R8
  flag_drop_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(irq_clear));
  // R8
  flag_rise_by_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> frame_event);
  // R6
  idle_parks_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> cnt_q == $past(top_value));
endmodule

bind lcd_frame_tally lcd_frame_tally_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .top_value(top_value),
  .frame_tick(frame_tick), .irq_clear(irq_clear),
  .frame_event(frame_event), .irq_flag(irq_flag), .cnt_q(cnt_q)
);

// File: tb/lcd_frame_tally_test.sv
module lcd_frame_tally_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [CNT_W-1:0] top_value = '0;
  logic [1:0] pre_sel = '0;
  logic frame_tick = 1'b0;
  logic irq_clear = 1'b0;
  logic frame_event, irq_flag;

  int checks = 0, fails = 0;
  int frames_left = 1;
  logic exp_ev = 1'b0, exp_flag = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_frame_tally #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .top_value(top_value),
    .pre_sel(pre_sel), .frame_tick(frame_tick), .irq_clear(irq_clear),
    .frame_event(frame_event), .irq_flag(irq_flag)
  );

  function automatic int period(input logic [CNT_W-1:0] t, input logic [1:0] s);
    return (int'(t) + 1) * (1 << s);
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // check outputs from the previous cycle, then model and drive the next one
  task automatic cycle(input logic en, input logic tick, input logic clr);
    logic coincide;
    @(negedge clk);
    check(tag, frame_event, exp_ev, "frame_event");
    check(exp_ev && irq_clear ? "R9" : "R8", irq_flag, exp_flag, "irq_flag");
    exp_ev = 1'b0;
    if (!en) frames_left = period(top_value, pre_sel);
    else if (tick) begin
      if (frames_left == 1) begin
        exp_ev = 1'b1;
        frames_left = period(top_value, pre_sel);
      end else frames_left--;
    end
    coincide = exp_ev & clr;
    exp_flag = exp_ev | (exp_flag & ~clr);
    if (coincide) tag = tag;
    enable = en; frame_tick = tick; irq_clear = clr;
  endtask

  task automatic setup(input logic [CNT_W-1:0] t, input logic [1:0] s);
    cycle(1'b0, 1'b0, 1'b1);
    top_value = t; pre_sel = s;
    cycle(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 1);
    rst_n = 1'b1;
    tag = "R1";
    cycle(1'b0, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);

    tag = "R2";
    top_value = 6'd0;
    for (int i = 0; i < 12; i++) cycle(1'b0, 1'b1, 1'b0);

    tag = "R3";
    setup(6'd3, 2'd0);
    for (int i = 0; i < 24; i++) cycle(1'b1, 1'b1, 1'b0);

    tag = "R4";
    for (int s = 1; s < 4; s++) begin
      setup(6'd2, 2'(s));
      for (int i = 0; i < 80; i++) cycle(1'b1, i[0], i % 7 == 3);
    end

    tag = "R5";
    setup(6'd0, 2'd0);
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b1, 1'b0);
    setup(6'd0, 2'd1);
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b1, 1'b1);

    tag = "R6";
    setup(6'd4, 2'd1);
    for (int i = 0; i < 7; i++) cycle(1'b1, 1'b1, 1'b0);
    cycle(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 25; i++) cycle(1'b1, 1'b1, 1'b0);

    tag = "R10";
    setup(6'd2, 2'd0);
    for (int i = 0; i < 40; i++) cycle(1'b1, i % 5 == 0, 1'b0);

    tag = "R9";
    setup(6'd0, 2'd0);
    for (int i = 0; i < 8; i++) cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b1, 1'b0, 1'b1);

    tag = "R7";
    for (int blk = 0; blk < 30; blk++) begin
      setup(CNT_W'($urandom_range(0, 9)), 2'($urandom_range(0, 3)));
      for (int i = 0; i < 150; i++)
        cycle($urandom_range(0, 99) != 0, $urandom_range(0, 2) == 0,
              $urandom_range(0, 5) == 0);
    end
    cycle(1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule